// File: doc/BRIEF.md
# Entropy CRC Conditioner

This block turns a few single-bit noise inputs into 64-bit random words. Each noise bit passes through its own enable gate. The gated bits are folded into one bit by XOR, and every clock cycle that bit is shifted into a 64-bit CRC accumulator. A consumer takes words from the accumulator through a valid/ready output stream. A programmable interlock holds the stream's valid low until enough accumulation cycles have passed since the previous word was taken, so each delivered word carries enough fresh input.

A single control register sets the behaviour: the source enables, an interlock mode bit, a wait count, a two-bit selector and a two-bit tuning code for each source. The selector and tuning fields drive no internal logic. They are only held and brought out on pins for the analog front end.

Back-pressure rules of the output stream:
- The block holds `dout_valid` high until a transfer happens, as long as no control write intervenes. A transfer is a cycle in which both `dout_valid` and `dout_ready` are high.
- The consumer may hold `dout_ready` low for as long as it likes, and nothing is lost while it waits.
- `dout_data` is the live accumulator, so it changes every cycle. The word delivered is the value present in the transfer cycle.

Top module: `entropy_crc_cond`

## Requirements
- R1: Reset values:
  - The accumulator holds the nonzero `SEED`.
  - The interlock cycle counter is zero.
  - The control register holds the standard configuration, so with a nonzero default wait `dout_valid` is low right after reset.
  - Standard configuration field layout, for three sources:
    - bits [2:0] source enables = 3'b111
    - bit 3 interlock mode = 1
    - bits [5:4] selector = 2
    - bits [11:6] tuning = 2'd1 for source 0, 2'd2 for source 1, 2'd3 for source 2 (source i at bits [7+2i:6+2i])
    - bits [15:12] reserved = 0
    - bits [16 +: CNT_W] wait count = `DEF_WAIT`
- R2: A source whose enable bit is 0 has no effect on the accumulator. The input bit is the XOR of `noise_i[i] & en[i]` over all sources.
- R3: Each cycle the accumulator A updates as A' = {A[62:0],0} XOR (P if (A[63] XOR d) else 0).
  - d is the input bit from R2.
  - P has ones at bits 61, 57, 56, 52, 51, 50, 48, 47, 46, 43, 42, 41, 39, 38, 37, 35, 32, 28, 25, 22, 21, 17, 15, 13, 12, 11, 7, 5, 1 and 0, which is the degree-64 polynomial without its x^64 term.
- R4: With the mode bit set, `dout_valid` is high exactly when the cycle counter is at least the wait count. The counter is cleared by reset and by each transfer, and adds one per cycle. The first word after reset therefore also waits.
- R5: With the mode bit clear, `dout_valid` is high in every cycle.
- R6: After a transfer with the mode bit set and a nonzero wait, `dout_valid` is low in the next cycle.
- R7: A control write changes `cfg_rdata` from the next cycle on, and `cfg_rdata` then equals the written word.
- R8: The cycle counter saturates at its maximum and does not wrap. With the wait set to that maximum, `dout_valid` stays high however long the consumer waits.
- R9: Once `dout_valid` is high, it stays high until a transfer, provided no control write occurs.
- R10: `sel_o` and `tune_o` always equal the selector and tuning fields of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noise_i | input | NUM_SRC | Raw noise bits, one per source |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | CTRL_W | Control register write value |
| cfg_rdata | output | CTRL_W | Current control register contents |
| tune_o | output | 2*NUM_SRC | Per-source tuning codes |
| sel_o | output | 2 | Selector field |
| dout_valid | output | 1 | A conditioned word may be taken |
| dout_ready | input | 1 | Consumer accepts the word |
| dout_data | output | 64 | Live accumulator value |

## Verification
Every output comes from a register, so the results of a stimulus applied before edge N show up after edge N:
- A noise bit changes the accumulator one edge later.
- A control write shows on `cfg_rdata`, `sel_o` and `tune_o` one edge later.
- After a transfer, `dout_valid` drops at the next edge and returns exactly wait-count edges after the transfer edge.

The bench drives inputs on the falling edge and samples outputs in the same low phase, after the rising edge has settled, so it counts edges rather than time. It runs its own model of the accumulator, updated on each rising edge from the noise it drove and the enables it wrote, and compares `dout_data` against that model every sampled cycle.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  localparam int DATA_W = 64;

  // degree-64 polynomial, x^64 term implicit
  localparam logic [DATA_W-1:0] CRC_TAPS =
      (64'd1 << 61) | (64'd1 << 57) | (64'd1 << 56) | (64'd1 << 52) |
      (64'd1 << 51) | (64'd1 << 50) | (64'd1 << 48) | (64'd1 << 47) |
      (64'd1 << 46) | (64'd1 << 43) | (64'd1 << 42) | (64'd1 << 41) |
      (64'd1 << 39) | (64'd1 << 38) | (64'd1 << 37) | (64'd1 << 35) |
      (64'd1 << 32) | (64'd1 << 28) | (64'd1 << 25) | (64'd1 << 22) |
      (64'd1 << 21) | (64'd1 << 17) | (64'd1 << 15) | (64'd1 << 13) |
      (64'd1 << 12) | (64'd1 << 11) | (64'd1 << 7)  | (64'd1 << 5)  |
      (64'd1 << 1)  | 64'd1;

  function automatic logic [DATA_W-1:0] crc_next(input logic [DATA_W-1:0] cur,
                                                 input logic din);
    crc_next = {cur[DATA_W-2:0], 1'b0} ^ ((cur[DATA_W-1] ^ din) ? CRC_TAPS : '0);
  endfunction

  // default tuning code: source i gets (i+1) mod 4, two bits each
  function automatic logic [31:0] tune_default(input int n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < n; i++) r[2*i +: 2] = 2'((i + 1) & 3);
    return r;
  endfunction

endpackage

// File: rtl/ecc_mixer.sv
module ecc_mixer #(
  parameter int NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] noise_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               mix_o
);
  logic [NUM_SRC-1:0] gated;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign gated[i] = noise_i[i] & en_i[i];
  end

  assign mix_o = ^gated;
endmodule

// File: rtl/ecc_crc_acc.sv
module ecc_crc_acc
  import ecc_pkg::*;
#(
  parameter logic [DATA_W-1:0] SEED = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  output logic [DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= SEED;
    else        acc_q <= crc_next(acc_q, bit_i);
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/ecc_interlock.sv
module ecc_interlock #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_en_i,
  input  logic [CNT_W-1:0] wait_i,
  input  logic             take_i,
  output logic             avail_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (take_i)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign avail_o = !lock_en_i || (cnt_q >= wait_i);
endmodule

// File: rtl/ecc_ctrl_reg.sv
module ecc_ctrl_reg #(
  parameter int           W       = 22,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q_o <= RST_VAL;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/entropy_crc_cond.sv
module entropy_crc_cond
  import ecc_pkg::*;
#(
  parameter int                NUM_SRC  = 3,
  parameter int                CNT_W    = 16,
  parameter int                DEF_WAIT = 5,
  parameter logic [DATA_W-1:0] SEED     = 64'h0123_4567_89AB_CDEF,
  localparam int               CTRL_W   = 16 + CNT_W,
  localparam int               TUNE_W   = 2 * NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] noise_i,
  input  logic               cfg_we,
  input  logic [CTRL_W-1:0]  cfg_wdata,
  output logic [CTRL_W-1:0]  cfg_rdata,
  output logic [TUNE_W-1:0]  tune_o,
  output logic [1:0]         sel_o,
  output logic               dout_valid,
  input  logic               dout_ready,
  output logic [DATA_W-1:0]  dout_data
);
  // control field positions
  localparam int MODE_BIT = NUM_SRC;
  localparam int SEL_LSB  = NUM_SRC + 1;
  localparam int TUNE_LSB = NUM_SRC + 3;
  localparam int WAIT_LSB = 16;

  localparam logic [CTRL_W-1:0] CTRL_DEF =
      (CTRL_W'(DEF_WAIT) << WAIT_LSB) |
      (CTRL_W'(tune_default(NUM_SRC)) << TUNE_LSB) |
      (CTRL_W'(2) << SEL_LSB) |
      (CTRL_W'(1) << MODE_BIT) |
      CTRL_W'((1 << NUM_SRC) - 1);

  logic [CTRL_W-1:0] ctrl_q;
  logic              mix_bit;
  logic              take;

  ecc_ctrl_reg #(.W(CTRL_W), .RST_VAL(CTRL_DEF)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .wdata_i (cfg_wdata),
    .q_o     (ctrl_q)
  );

  ecc_mixer #(.NUM_SRC(NUM_SRC)) u_mix (
    .noise_i (noise_i),
    .en_i    (ctrl_q[NUM_SRC-1:0]),
    .mix_o   (mix_bit)
  );

  ecc_crc_acc #(.SEED(SEED)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .bit_i (mix_bit),
    .acc_o (dout_data)
  );

  assign take = dout_valid & dout_ready;

  ecc_interlock #(.CNT_W(CNT_W)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_en_i (ctrl_q[MODE_BIT]),
    .wait_i    (ctrl_q[WAIT_LSB +: CNT_W]),
    .take_i    (take),
    .avail_o   (dout_valid)
  );

  assign cfg_rdata = ctrl_q;
  assign sel_o     = ctrl_q[SEL_LSB +: 2];
  assign tune_o    = ctrl_q[TUNE_LSB +: TUNE_W];
endmodule

// File: rtl/ecc_checker.sv
module ecc_checker
  import ecc_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int CNT_W   = 16,
  parameter int CTRL_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] noise_i,
  input logic               cfg_we,
  input logic [CTRL_W-1:0]  cfg_wdata,
  input logic [CTRL_W-1:0]  cfg_rdata,
  input logic               dout_valid,
  input logic               dout_ready,
  input logic [DATA_W-1:0]  dout_data
);
  localparam int MODE_BIT = NUM_SRC;
  localparam int WAIT_LSB = 16;

  logic             mode;
  logic [CNT_W-1:0] waitv;
  logic             din;

  assign mode  = cfg_rdata[MODE_BIT];
  assign waitv = cfg_rdata[WAIT_LSB +: CNT_W];
  assign din   = ^(noise_i & cfg_rdata[NUM_SRC-1:0]);

  // R2, R3: accumulator steps by the gated input bit
  p_crc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dout_data == crc_next($past(dout_data), $past(din)));

  // R5: no interlock when mode bit is clear
  p_nolock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> dout_valid);

  // R6: a transfer closes the window
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && dout_ready && mode && waitv != '0 && !cfg_we) |=> !dout_valid);

  // R7: control write visible next cycle
  p_cfg_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  // R9: valid holds under back-pressure
  p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready && !cfg_we) |=> dout_valid);
endmodule

bind entropy_crc_cond ecc_checker #(
  .NUM_SRC (NUM_SRC),
  .CNT_W   (CNT_W),
  .CTRL_W  (CTRL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .noise_i    (noise_i),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .dout_valid (dout_valid),
  .dout_ready (dout_ready),
  .dout_data  (dout_data)
);

// File: tb/entropy_crc_cond_tb_top.sv
module entropy_crc_cond_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          NSRC       = 3;
  localparam int          CW         = 6;
  localparam int          DW         = 5;
  localparam int          CTW        = 16 + CW;
  localparam logic [63:0] SEEDV      = 64'hFEED_0000_C0DE_1234;
  localparam int          WD_LIMIT   = 20000;

  localparam logic [63:0] P =
      (64'd1 << 61) | (64'd1 << 57) | (64'd1 << 56) | (64'd1 << 52) |
      (64'd1 << 51) | (64'd1 << 50) | (64'd1 << 48) | (64'd1 << 47) |
      (64'd1 << 46) | (64'd1 << 43) | (64'd1 << 42) | (64'd1 << 41) |
      (64'd1 << 39) | (64'd1 << 38) | (64'd1 << 37) | (64'd1 << 35) |
      (64'd1 << 32) | (64'd1 << 28) | (64'd1 << 25) | (64'd1 << 22) |
      (64'd1 << 21) | (64'd1 << 17) | (64'd1 << 15) | (64'd1 << 13) |
      (64'd1 << 12) | (64'd1 << 11) | (64'd1 << 7)  | (64'd1 << 5)  |
      (64'd1 << 1)  | 64'd1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] noise_i = '0;
  logic            cfg_we = 1'b0;
  logic [CTW-1:0]  cfg_wdata = '0;
  logic [CTW-1:0]  cfg_rdata;
  logic [5:0]      tune_o;
  logic [1:0]      sel_o;
  logic            dout_valid;
  logic            dout_ready = 1'b0;
  logic [63:0]     dout_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  logic [63:0]     m_acc;
  logic [NSRC-1:0] m_en;

  entropy_crc_cond #(
    .NUM_SRC (NSRC),
    .CNT_W   (CW),
    .DEF_WAIT(DW),
    .SEED    (SEEDV)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .noise_i    (noise_i),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .tune_o     (tune_o),
    .sel_o      (sel_o),
    .dout_valid (dout_valid),
    .dout_ready (dout_ready),
    .dout_data  (dout_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [CTW-1:0] mk_ctrl(input logic [2:0] en, input logic mode,
                                             input logic [1:0] sel, input logic [5:0] tune,
                                             input logic [CW-1:0] w);
    return {w, 4'h0, tune, sel, mode, en};
  endfunction

  // reference accumulator from R2/R3
  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc <= SEEDV;
      m_en  <= 3'b111;
    end else begin
      m_acc <= {m_acc[62:0], 1'b0} ^ ((m_acc[63] ^ (^(noise_i & m_en))) ? P : 64'd0);
      if (cfg_we) m_en <= cfg_wdata[2:0];
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [CTW-1:0] v);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    tick();
    cfg_we    = 1'b0;
  endtask

  // R1, R10: reset values
  task automatic t_reset();
    logic [CTW-1:0] def;
    def = mk_ctrl(3'b111, 1'b1, 2'd2, 6'b11_10_01, CW'(DW));
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    check(dout_data == SEEDV, "R1 seed", dout_data, SEEDV);
    check(cfg_rdata == def, "R1 ctrl default", 64'(cfg_rdata), 64'(def));
    check(dout_valid == 1'b0, "R1 valid low", 64'(dout_valid), 64'd0);
    check(tune_o == 6'b11_10_01 && sel_o == 2'd2, "R10 default fields",
          64'({tune_o, sel_o}), 64'({6'b11_10_01, 2'd2}));
  endtask

  // R4: first word after reset waits DW cycles
  task automatic t_first_wait();
    for (int k = 1; k <= DW; k++) begin
      tick();
      check(dout_valid == (k >= DW), "R4 first wait", 64'(dout_valid), 64'(k >= DW));
    end
  endtask

  // R3: accumulator tracks random noise with all sources on
  task automatic t_crc();
    int bad = 0;
    for (int k = 0; k < 40; k++) begin
      noise_i = NSRC'($urandom);
      tick();
      if (dout_data != m_acc) bad++;
    end
    check(bad == 0 && dout_data == m_acc, "R3 crc stream", dout_data, m_acc);
    noise_i = 3'b001;
    tick();
    check(dout_data == m_acc, "R3 single bit", dout_data, m_acc);
  endtask

  // R2: disabled sources ignored
  task automatic t_gating();
    logic [63:0] exp;
    write_ctrl(mk_ctrl(3'b000, 1'b1, 2'd2, 6'h39, CW'(DW)));
    exp = dout_data;
    for (int k = 0; k < 10; k++) begin
      noise_i = 3'b111;
      exp = {exp[62:0], 1'b0} ^ (exp[63] ? P : 64'd0);
      tick();
    end
    check(dout_data == exp, "R2 all disabled", dout_data, exp);
    write_ctrl(mk_ctrl(3'b101, 1'b1, 2'd2, 6'h39, CW'(DW)));
    for (int k = 0; k < 20; k++) begin
      noise_i = NSRC'($urandom);
      tick();
    end
    check(dout_data == m_acc, "R2 partial enables", dout_data, m_acc);
  endtask

  // R7, R10: control write timing and field export
  task automatic t_cfg();
    logic [CTW-1:0] old, v;
    old = cfg_rdata;
    v = mk_ctrl(3'b111, 1'b0, 2'd1, 6'h2A, CW'(3));
    cfg_we = 1'b1;
    cfg_wdata = v;
    #1;
    check(cfg_rdata == old, "R7 not before edge", 64'(cfg_rdata), 64'(old));
    tick();
    cfg_we = 1'b0;
    check(cfg_rdata == v, "R7 after edge", 64'(cfg_rdata), 64'(v));
    check(tune_o == 6'h2A && sel_o == 2'd1, "R10 fields follow",
          64'({tune_o, sel_o}), 64'({6'h2A, 2'd1}));
  endtask

  // R5: mode clear never stalls
  task automatic t_nolock();
    int bad = 0;
    dout_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      if (!dout_valid) bad++;
      tick();
    end
    dout_ready = 1'b0;
    check(bad == 0, "R5 never stalls", 64'(bad), 64'd0);
  endtask

  // R6, R4: transfer restarts the window
  task automatic t_restart();
    int guard = 0;
    write_ctrl(mk_ctrl(3'b111, 1'b1, 2'd2, 6'h39, CW'(4)));
    while (!dout_valid && guard < 100) begin
      tick();
      guard++;
    end
    check(dout_valid == 1'b1, "R4 window opens", 64'(dout_valid), 64'd1);
    check(dout_data == m_acc, "R3 delivered word", dout_data, m_acc);
    dout_ready = 1'b1;
    tick();
    dout_ready = 1'b0;
    check(dout_valid == 1'b0, "R6 low after transfer", 64'(dout_valid), 64'd0);
    for (int j = 1; j <= 4; j++) begin
      tick();
      check(dout_valid == (j >= 4), "R4 wait after transfer", 64'(dout_valid), 64'(j >= 4));
    end
  endtask

  // R9: valid holds under back-pressure
  task automatic t_hold();
    int bad = 0;
    for (int k = 0; k < 10; k++) begin
      tick();
      if (!dout_valid) bad++;
    end
    check(bad == 0, "R9 hold", 64'(bad), 64'd0);
  endtask

  // R8: counter saturates, wait at maximum
  task automatic t_sat();
    int drops = 0;
    bit seen = 0;
    write_ctrl(mk_ctrl(3'b111, 1'b1, 2'd2, 6'h39, '1));
    dout_ready = 1'b1;
    tick();
    dout_ready = 1'b0;
    for (int k = 0; k < 200; k++) begin
      tick();
      if (dout_valid) seen = 1;
      else if (seen) drops++;
    end
    check(seen && drops == 0, "R8 saturate", 64'(drops), 64'd0);
    check(dout_valid == 1'b1, "R8 still valid", 64'(dout_valid), 64'd1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_first_wait();
    t_crc();
    t_gating();
    t_cfg();
    t_nolock();
    t_restart();
    t_hold();
    t_sat();
    done = 1;
    summary();
  end
endmodule